// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block is the byte-wide internal data store of a small 8-bit controller core. It holds 256 bytes of RAM, split into a lower half and an upper half, and it owns a request/response port toward the special-function registers. The core presents one request at a time. Each request has an 8-bit address, a mode flag (direct or pointer-indirect), a write enable and write data. Read results come back with `rd_valid` one cycle after a direct request, or two cycles after an indirect one.

The upper half of the address map is shared. In direct mode an address at 80h or above reaches the register port. In indirect mode the same address reaches the upper RAM. An indirect request does not carry its target address. It names one of two pointer registers (first or second of the active bank). The block reads that pointer out of the lower RAM, where the four eight-byte register banks sit at 00h–1Fh, and then uses the pointer as the target address. Bytes 20h–7Fh are plain byte storage for this block.

Top module: `dual_space_dmem`

## Requirements
- R1: A direct request to an address below 80h reads or writes the lower RAM. A read returns the byte with `rd_valid` high in the cycle after acceptance. A write leaves `rd_valid` low.
- R2: A direct write to 80h–FFh raises `sfr_we` for one cycle, in the cycle after acceptance, with `sfr_addr` and `sfr_wdata` equal to the request. It does not change the upper RAM.
- R3: A direct read of 80h–FFh raises `sfr_re` with `sfr_addr` in the cycle after acceptance. In that same cycle `rd_valid` is high and `rd_data` equals `sfr_rdata`.
- R4: An indirect request takes its pointer from lower RAM address bank×8 when `req_ptr_sel`=0, and from bank×8+1 when `req_ptr_sel`=1. The bank is the 2-bit `bank_sel`.
- R5: An indirect request whose pointer is 80h or above reads or writes the upper RAM. It never raises `sfr_we` or `sfr_re`.
- R6: An indirect request whose pointer is below 80h reads or writes the same lower RAM bytes that direct mode reaches.
- R7: After an indirect request is accepted, `busy` is high for exactly the next cycle. Read data is returned with `rd_valid` one cycle after that.
- R8: A request presented while `busy` is high is ignored and causes no SFR strobe or RAM change.
- R9: A direct write and an indirect write to the same upper address (for example 90h) land in two independent locations. Neither one disturbs the other.
- R10: While reset is asserted, `busy`, `rd_valid`, `sfr_we` and `sfr_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_indirect | input | 1 | 1 = pointer-indirect mode, 0 = direct mode |
| req_ptr_sel | input | 1 | Pointer register select: 0 = first, 1 = second of the bank |
| bank_sel | input | 2 | Active register bank |
| req_addr | input | 8 | Direct-mode address |
| req_we | input | 1 | Write enable |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Pointer fetch in progress; new requests ignored |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| sfr_we | output | 1 | Register-port write strobe |
| sfr_re | output | 1 | Register-port read strobe |
| sfr_addr | output | 8 | Register-port address |
| sfr_wdata | output | 8 | Register-port write data |
| sfr_rdata | input | 8 | Register-port read data, valid while `sfr_re` is high |

## Verification
Direct traffic covers the lower-RAM region boundaries (00h, 1Fh, 20h, 2Fh, 30h, 7Fh) and register-port addresses at 80h, 90h and FFh. This shows that address bit 7 alone steers direct accesses. Indirect traffic walks all four banks with both pointer selects, with pointers loaded to distinct values, so that a wrong bank or pointer offset lands on a different byte. The same-address pattern at 90h, written once through each mode and read back through each mode, separates the register port from the upper RAM. A direct register write held on the request lines during the busy cycle must show no strobe.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 8;
    localparam int BANK_W        = 2;
    localparam int REGS_PER_BANK = 8;
    localparam int HALF_DEPTH    = 2 ** (ADDR_W - 1);
    localparam int HALF_AW       = ADDR_W - 1;

    typedef enum logic [1:0] {
        TGT_LOW = 2'd0,
        TGT_UP  = 2'd1,
        TGT_SFR = 2'd2
    } tgt_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

    typedef struct packed {
        st_e               st;
        logic              pend_we;
        logic [DATA_W-1:0] pend_wdata;
        logic              rd_valid;
        tgt_e              rd_src;
        logic              sfr_we;
        logic              sfr_re;
        logic [ADDR_W-1:0] sfr_addr;
        logic [DATA_W-1:0] sfr_wdata;
    } ctrl_t;
endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata_q   <= mem[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              indirect,
    output tgt_e              tgt
);
    always_comb begin
        if (!addr[ADDR_W-1])  tgt = TGT_LOW;
        else if (indirect)    tgt = TGT_UP;
        else                  tgt = TGT_SFR;
    end
endmodule

// File: rtl/dual_space_dmem.sv
module dual_space_dmem
    import dmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_indirect,
    input  logic              req_ptr_sel,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sfr_we,
    output logic              sfr_re,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    localparam int NHALF = 2;

    ctrl_t ctrl_d, ctrl_q;

    logic [NHALF-1:0]              ram_en;
    logic [NHALF-1:0]              ram_we;
    logic [NHALF-1:0][HALF_AW-1:0] ram_addr;
    logic [NHALF-1:0][DATA_W-1:0]  ram_rdata;
    logic [DATA_W-1:0]             ram_wdata;

    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_ind;
    logic              acc_we;
    logic [DATA_W-1:0] acc_wdata;
    tgt_e              acc_tgt;
    logic              ptr_fetch;
    logic [HALF_AW-1:0] ptr_loc;

    // Location of the chosen pointer register inside the active bank
    assign ptr_loc = HALF_AW'(bank_sel) * HALF_AW'(REGS_PER_BANK) + HALF_AW'(req_ptr_sel);

    // Which access is performed this cycle
    always_comb begin
        acc_valid = 1'b0;
        acc_addr  = req_addr;
        acc_ind   = 1'b0;
        acc_we    = req_we;
        acc_wdata = req_wdata;
        ptr_fetch = 1'b0;
        if (ctrl_q.st == ST_FETCH) begin
            acc_valid = 1'b1;
            acc_addr  = ram_rdata[0];
            acc_ind   = 1'b1;
            acc_we    = ctrl_q.pend_we;
            acc_wdata = ctrl_q.pend_wdata;
        end else if (req_valid) begin
            if (req_indirect) ptr_fetch = 1'b1;
            else              acc_valid = 1'b1;
        end
    end

    dmem_decode u_decode (
        .addr     (acc_addr),
        .indirect (acc_ind),
        .tgt      (acc_tgt)
    );

    // Next-state and RAM port steering
    always_comb begin
        ctrl_d          = ctrl_q;
        ctrl_d.rd_valid = 1'b0;
        ctrl_d.sfr_we   = 1'b0;
        ctrl_d.sfr_re   = 1'b0;
        ram_en          = '0;
        ram_we          = '0;
        ram_addr        = '0;
        ram_wdata       = acc_wdata;

        if (ptr_fetch) begin
            ram_en[0]         = 1'b1;
            ram_addr[0]       = ptr_loc;
            ctrl_d.st         = ST_FETCH;
            ctrl_d.pend_we    = req_we;
            ctrl_d.pend_wdata = req_wdata;
        end

        if (acc_valid) begin
            ctrl_d.st       = ST_IDLE;
            ctrl_d.rd_valid = !acc_we;
            ctrl_d.rd_src   = acc_tgt;
            unique case (acc_tgt)
                TGT_LOW: begin
                    ram_en[0]   = 1'b1;
                    ram_we[0]   = acc_we;
                    ram_addr[0] = acc_addr[HALF_AW-1:0];
                end
                TGT_UP: begin
                    ram_en[1]   = 1'b1;
                    ram_we[1]   = acc_we;
                    ram_addr[1] = acc_addr[HALF_AW-1:0];
                end
                default: begin
                    ctrl_d.sfr_we    = acc_we;
                    ctrl_d.sfr_re    = !acc_we;
                    ctrl_d.sfr_addr  = acc_addr;
                    ctrl_d.sfr_wdata = acc_wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, rd_src: TGT_LOW, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    genvar h;
    generate
        for (h = 0; h < NHALF; h++) begin : g_half
            dmem_ram #(
                .DEPTH (HALF_DEPTH),
                .DW    (DATA_W)
            ) u_ram (
                .clk   (clk),
                .en    (ram_en[h]),
                .we    (ram_we[h]),
                .addr  (ram_addr[h]),
                .wdata (ram_wdata),
                .rdata (ram_rdata[h])
            );
        end
    endgenerate

    always_comb begin
        unique case (ctrl_q.rd_src)
            TGT_UP:  rd_data = ram_rdata[1];
            TGT_SFR: rd_data = sfr_rdata;
            default: rd_data = ram_rdata[0];
        endcase
    end

    assign busy      = (ctrl_q.st == ST_FETCH);
    assign rd_valid  = ctrl_q.rd_valid;
    assign sfr_we    = ctrl_q.sfr_we;
    assign sfr_re    = ctrl_q.sfr_re;
    assign sfr_addr  = ctrl_q.sfr_addr;
    assign sfr_wdata = ctrl_q.sfr_wdata;

    // A register-port write comes only from an accepted direct upper write
    p_sfr_we_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> $past(req_valid && !busy && !req_indirect && req_we && req_addr[ADDR_W-1]));

    p_sfr_we_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> (sfr_addr == $past(req_addr) && sfr_wdata == $past(req_wdata)));

    // A register-port read comes only from an accepted direct upper read
    p_sfr_re_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_re |-> $past(req_valid && !busy && !req_indirect && !req_we && req_addr[ADDR_W-1]));

    p_indirect_no_sfr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!sfr_we && !sfr_re));

    p_busy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_busy_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_indirect && !busy) |=> busy);

    p_write_no_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_indirect && req_we) |=> !rd_valid);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && sfr_re));
endmodule

// File: tb/dual_space_dmem_tb.sv
`timescale 1ns/1ps
module dual_space_dmem_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_indirect = 1'b0;
    logic       req_ptr_sel = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic [7:0] req_addr = 8'd0;
    logic       req_we = 1'b0;
    logic [7:0] req_wdata = 8'd0;
    logic       busy, rd_valid, sfr_we, sfr_re;
    logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;

    always #2.5 clk = ~clk;

    dual_space_dmem dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indirect(req_indirect),
        .req_ptr_sel(req_ptr_sel), .bank_sel(bank_sel), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // Simple register peripheral behind the port
    logic [7:0] periph [128];
    assign sfr_rdata = sfr_re ? periph[sfr_addr[6:0]] : 8'h00;
    always @(posedge clk) if (sfr_we) periph[sfr_addr[6:0]] <= sfr_wdata;

    // Reference model
    int unsigned m_low [128];
    int unsigned m_up  [128];
    int unsigned m_sfr [128];

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Direct access: R1, R2, R3
    task automatic direct(input logic [7:0] a, input bit we, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_indirect = 1'b0; req_addr = a; req_we = we; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 busy after direct", busy, 0);
        if (we && a[7]) begin
            chk("R2 sfr_we", sfr_we, 1);
            chk("R2 sfr_addr", sfr_addr, a);
            chk("R2 sfr_wdata", sfr_wdata, d);
            chk("R1 rd_valid on write", rd_valid, 0);
            m_sfr[a[6:0]] = d;
        end else if (we) begin
            chk("R1 no sfr_we", sfr_we, 0);
            chk("R1 rd_valid on write", rd_valid, 0);
            m_low[a[6:0]] = d;
        end else if (a[7]) begin
            chk("R3 sfr_re", sfr_re, 1);
            chk("R3 sfr_addr", sfr_addr, a);
            chk("R3 rd_valid", rd_valid, 1);
            chk("R3 rd_data", rd_data, m_sfr[a[6:0]]);
        end else begin
            chk("R1 no sfr_re", sfr_re, 0);
            chk("R1 rd_valid", rd_valid, 1);
            chk("R1 rd_data", rd_data, m_low[a[6:0]]);
        end
    endtask

    // Indirect access: R4..R8; poke holds a direct SFR write during busy
    task automatic indirect(input bit sel, input logic [1:0] bank, input bit we,
                            input logic [7:0] d, input bit poke);
        int unsigned ptr;
        @(negedge clk);
        req_valid = 1'b1; req_indirect = 1'b1; req_ptr_sel = sel; bank_sel = bank;
        req_we = we; req_wdata = d; req_addr = 8'h00;
        @(negedge clk);
        if (poke) begin
            req_indirect = 1'b0; req_addr = 8'hC0; req_we = 1'b1; req_wdata = 8'hEE;
        end else begin
            req_valid = 1'b0;
        end
        chk("R7 busy high", busy, 1);
        chk("R7 no early rd_valid", rd_valid, 0);
        ptr = m_low[bank * 8 + sel];
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 busy low", busy, 0);
        chk("R5 R8 no sfr_we", sfr_we, 0);
        chk("R5 no sfr_re", sfr_re, 0);
        if (we) begin
            chk("R7 rd_valid on write", rd_valid, 0);
            if (ptr >= 128) m_up[ptr - 128] = d;
            else            m_low[ptr]      = d;
        end else begin
            chk("R7 rd_valid", rd_valid, 1);
            if (ptr >= 128) chk("R5 upper data", rd_data, m_up[ptr - 128]);
            else            chk("R6 lower data", rd_data, m_low[ptr]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk("watchdog", 1, 0);
        report();
    end

    initial begin
        // R10: quiet outputs during reset
        repeat (3) @(negedge clk);
        chk("R10 busy", busy, 0);
        chk("R10 rd_valid", rd_valid, 0);
        chk("R10 sfr_we", sfr_we, 0);
        chk("R10 sfr_re", sfr_re, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy after release", busy, 0);

        // R1: lower RAM region boundaries
        direct(8'h00, 1, 8'h3C); direct(8'h1F, 1, 8'hC3);
        direct(8'h20, 1, 8'h5A); direct(8'h2F, 1, 8'hA5);
        direct(8'h30, 1, 8'h01); direct(8'h7F, 1, 8'hFE);
        direct(8'h00, 0, 8'h0); direct(8'h1F, 0, 8'h0);
        direct(8'h20, 0, 8'h0); direct(8'h2F, 0, 8'h0);
        direct(8'h30, 0, 8'h0); direct(8'h7F, 0, 8'h0);

        // R2, R3: register port
        direct(8'h80, 1, 8'h11); direct(8'h90, 1, 8'h22); direct(8'hFF, 1, 8'h33);
        direct(8'h80, 0, 8'h0); direct(8'h90, 0, 8'h0); direct(8'hFF, 0, 8'h0);

        // R4: distinct pointer values in every bank, both selects
        for (int b = 0; b < 4; b++) begin
            direct(8'(b * 8),     1, 8'(8'hA0 + b * 2));
            direct(8'(b * 8 + 1), 1, 8'(8'h50 + b * 2));
        end
        for (int b = 0; b < 4; b++) begin
            indirect(1'b0, 2'(b), 1, 8'(8'h70 + b), 0);   // R5 upper write
            indirect(1'b1, 2'(b), 1, 8'(8'h60 + b), 0);   // R6 lower write
        end
        for (int b = 0; b < 4; b++) begin
            indirect(1'b0, 2'(b), 0, 8'h0, 0);            // R4 R5 read back
            indirect(1'b1, 2'(b), 0, 8'h0, 0);            // R4 R6 read back
        end
        // R6: direct view of indirectly written lower bytes
        direct(8'h50, 0, 8'h0); direct(8'h56, 0, 8'h0);

        // R9: same address 90h through both modes
        direct(8'h00, 1, 8'h90);
        direct(8'h90, 1, 8'h11);
        indirect(1'b0, 2'd0, 1, 8'h22, 0);
        direct(8'h90, 0, 8'h0);                 // R9 expects 11h
        indirect(1'b0, 2'd0, 0, 8'h0, 0);       // R9 expects 22h
        direct(8'h90, 1, 8'h44);
        indirect(1'b0, 2'd0, 0, 8'h0, 0);       // R9 upper still 22h
        indirect(1'b0, 2'd0, 1, 8'h55, 0);
        direct(8'h90, 0, 8'h0);                 // R9 port still 44h

        // R8: a direct register write held during busy is dropped
        direct(8'hC0, 1, 8'h12);
        indirect(1'b1, 2'd2, 0, 8'h0, 1);
        direct(8'hC0, 0, 8'h0);                 // R8 still 12h

        // Pointer at 7Fh / 80h edges of R6 / R5
        direct(8'h19, 1, 8'h7F);
        indirect(1'b1, 2'd3, 1, 8'h9D, 0);
        direct(8'h7F, 0, 8'h0);
        direct(8'h19, 1, 8'h80);
        indirect(1'b1, 2'd3, 1, 8'hD9, 0);
        indirect(1'b1, 2'd3, 0, 8'h0, 0);
        direct(8'h80, 0, 8'h0);                 // R2 R9 port 80h unchanged

        repeat (2) @(negedge clk);
        report();
    end
endmodule